// File: doc/BRIEF.md
# Bus Cycle Wait-State Sequencer

This block sequences the clock states of one bus cycle for a small processor bus interface. A cycle runs through T1, T2 and T3. From T3 it either finishes in T4 or stretches with wait states (TW) for as long as the addressed device is not ready. The bus is normally ready: a wait state is added only when both ready lines are pulled low. One ready line is synchronous to the clock. The other is asynchronous and is brought into the clock domain by a flop chain.

The block does not start a cycle while any idle cause is present. The idle causes are a full prefetch queue, an address calculation in progress, and a halt or wait instruction. A cycle flagged as special, such as an interrupt acknowledge or a locked transfer, is followed by a fixed run of idle states before the next cycle may begin. Outputs give the current state code, a one-clock completion pulse and an idle flag. The address and data paths are out of scope.

Top module: `bus_tstate_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is IDLE (`tstate`=0), `idle_o`=1 and `cycle_done`=0.
- R2: State codes are IDLE=0, T1=1, T2=2, T3=3, TW=4, T4=5. From IDLE with `bus_req`=1 and no hold, the machine enters T1, then T2 and T3 on the following clocks.
- R3: In T3 or TW the next state is TW when both the synchronised asynchronous ready and the sampled synchronous ready are 0. Otherwise the next state is T4.
- R4: A change on `rdy_async` takes effect at the state decision after SYNC_STAGES rising edges (two by default). The synchroniser resets to ready (1).
- R5: With FALL_SAMPLE=1, `rdy_sync` is captured on the falling edge in the middle of a cycle and is used at the next rising edge.
- R6: `cycle_done` is 1 exactly in T4, so it is a single-clock pulse for each cycle.
- R7: Any set bit of `idle_cause` (bit0 queue full, bit1 address calculation, bit2 halt/wait) keeps IDLE from starting a cycle and sends T4 to IDLE.
- R8: From T4 with `bus_req`=1, no idle cause and a non-special cycle, the next state is T1 with no idle state between.
- R9: `special_req` is captured when a cycle enters T1. After such a cycle, T4 goes to IDLE, and the machine stays in IDLE for SPECIAL_GAP further clocks before it can start again.
- R10: `idle_o` is 1 exactly when the state is IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_req | input | 1 | A bus cycle is wanted |
| rdy_async | input | 1 | Asynchronous ready, active high |
| rdy_sync | input | 1 | Synchronous ready, active high |
| idle_cause | input | NUM_CAUSES | Idle causes that block cycle start |
| special_req | input | 1 | Cycle being started needs trailing idle states |
| tstate | output | 3 | Current state code |
| cycle_done | output | 1 | High during T4 |
| idle_o | output | 1 | High during IDLE |

## Verification
On every cycle, the assertions check the fixed T1-to-T2-to-T3 order, the choice between TW and T4 from the combined ready, the rule that an active hold keeps IDLE, the single-clock completion pulse, and the forced return to IDLE after a special cycle. Some behaviours can only be shown by the bench's scenarios, because each one ties a port stimulus to a later state. These are the exact synchroniser latency on the asynchronous ready, the mid-cycle capture of the synchronous ready, the length of the gap after a special cycle, and back-to-back chaining. The bench compares every cycle against a model driven from the requirements.

// File: rtl/bts_pkg.sv
package bts_pkg;
   localparam int TS_W = 3;
   typedef enum logic [TS_W-1:0] {
      TS_IDLE = 3'd0,
      TS_T1   = 3'd1,
      TS_T2   = 3'd2,
      TS_T3   = 3'd3,
      TS_TW   = 3'd4,
      TS_T4   = 3'd5
   } tstate_e;
endpackage

// File: rtl/bts_async_sync.sv
module bts_async_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic async_i,
   output logic sync_o
);
   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("bts_async_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (rst) chain_q <= '1;
            else     chain_q <= async_i;
         end
      end else begin : g_multi
         always_ff @(posedge clk) begin
            if (rst) chain_q <= '1;
            else     chain_q <= {chain_q[STAGES-2:0], async_i};
         end
      end
   endgenerate

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/bts_srdy_sample.sv
module bts_srdy_sample #(
   parameter bit FALL_SAMPLE = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic rdy_i,
   output logic rdy_o
);
   logic smp_q;

   generate
      if (FALL_SAMPLE) begin : g_fall
         always_ff @(negedge clk) begin
            if (rst) smp_q <= 1'b1;
            else     smp_q <= rdy_i;
         end
      end else begin : g_rise
         always_ff @(posedge clk) begin
            if (rst) smp_q <= 1'b1;
            else     smp_q <= rdy_i;
         end
      end
   endgenerate

   assign rdy_o = smp_q;
endmodule

// File: rtl/bts_start_gate.sv
module bts_start_gate #(
   parameter int NUM_CAUSES  = 3,
   parameter int SPECIAL_GAP = 2
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [NUM_CAUSES-1:0] cause_i,
   input  logic                  special_i,
   input  logic                  start_i,
   input  logic                  in_t4_i,
   output logic                  hold_o,
   output logic                  special_o
);
   localparam int GW = $clog2(SPECIAL_GAP + 2);
   localparam logic [GW-1:0] GAP_LOAD = GW'(SPECIAL_GAP);

   generate
      if (NUM_CAUSES < 1) begin : g_bad_causes
         $error("bts_start_gate: NUM_CAUSES must be at least 1");
      end
      if (SPECIAL_GAP < 0) begin : g_bad_gap
         $error("bts_start_gate: SPECIAL_GAP must not be negative");
      end
   endgenerate

   logic          spec_q;
   logic [GW-1:0] gap_q;

   always_ff @(posedge clk) begin
      if (rst)          spec_q <= 1'b0;
      else if (start_i) spec_q <= special_i;
   end

   always_ff @(posedge clk) begin
      if (rst)                  gap_q <= '0;
      else if (in_t4_i && spec_q) gap_q <= GAP_LOAD;
      else if (gap_q != '0)     gap_q <= gap_q - 1'b1;
   end

   assign hold_o    = (|cause_i) || (gap_q != '0);
   assign special_o = spec_q;

   assert_gap_counts_down_R9: assert property (@(posedge clk) disable iff (rst)
      (gap_q != '0 && !in_t4_i) |=> (gap_q == $past(gap_q) - 1'b1));
endmodule

// File: rtl/bts_tstate_fsm.sv
module bts_tstate_fsm
   import bts_pkg::*;
(
   input  logic    clk,
   input  logic    rst,
   input  logic    req_i,
   input  logic    hold_i,
   input  logic    special_i,
   input  logic    ready_i,
   output tstate_e state_o,
   output logic    start_o
);
   tstate_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         TS_IDLE: state_d = (req_i && !hold_i) ? TS_T1 : TS_IDLE;
         TS_T1:   state_d = TS_T2;
         TS_T2:   state_d = TS_T3;
         TS_T3,
         TS_TW:   state_d = ready_i ? TS_T4 : TS_TW;
         TS_T4:   state_d = (req_i && !hold_i && !special_i) ? TS_T1 : TS_IDLE;
         default: state_d = TS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= TS_IDLE;
      else     state_q <= state_d;
   end

   assign state_o = state_q;
   assign start_o = (state_d == TS_T1);

   assert_t1_then_t2_R2: assert property (@(posedge clk) disable iff (rst)
      (state_q == TS_T1) |=> (state_q == TS_T2));
   assert_t2_then_t3_R2: assert property (@(posedge clk) disable iff (rst)
      (state_q == TS_T2) |=> (state_q == TS_T3));
   assert_wait_when_unready_R3: assert property (@(posedge clk) disable iff (rst)
      ((state_q == TS_T3 || state_q == TS_TW) && !ready_i) |=> (state_q == TS_TW));
   assert_exit_when_ready_R3: assert property (@(posedge clk) disable iff (rst)
      ((state_q == TS_T3 || state_q == TS_TW) && ready_i) |=> (state_q == TS_T4));
   assert_hold_keeps_idle_R7: assert property (@(posedge clk) disable iff (rst)
      (state_q == TS_IDLE && hold_i) |=> (state_q == TS_IDLE));
endmodule

// File: rtl/bus_tstate_seq.sv
module bus_tstate_seq
   import bts_pkg::*;
#(
   parameter int NUM_CAUSES  = 3,
   parameter int SYNC_STAGES = 2,
   parameter int SPECIAL_GAP = 2,
   parameter bit FALL_SAMPLE = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  bus_req,
   input  logic                  rdy_async,
   input  logic                  rdy_sync,
   input  logic [NUM_CAUSES-1:0] idle_cause,
   input  logic                  special_req,
   output logic [TS_W-1:0]       tstate,
   output logic                  cycle_done,
   output logic                  idle_o
);
   logic    a_rdy, s_rdy, hold, spec, start;
   tstate_e st;

   bts_async_sync #(.STAGES(SYNC_STAGES)) u_async (
      .clk(clk), .rst(rst), .async_i(rdy_async), .sync_o(a_rdy));

   bts_srdy_sample #(.FALL_SAMPLE(FALL_SAMPLE)) u_srdy (
      .clk(clk), .rst(rst), .rdy_i(rdy_sync), .rdy_o(s_rdy));

   bts_start_gate #(.NUM_CAUSES(NUM_CAUSES), .SPECIAL_GAP(SPECIAL_GAP)) u_gate (
      .clk(clk), .rst(rst), .cause_i(idle_cause), .special_i(special_req),
      .start_i(start), .in_t4_i(st == TS_T4), .hold_o(hold), .special_o(spec));

   bts_tstate_fsm u_fsm (
      .clk(clk), .rst(rst), .req_i(bus_req), .hold_i(hold), .special_i(spec),
      .ready_i(a_rdy | s_rdy), .state_o(st), .start_o(start));

   assign tstate     = st;
   assign cycle_done = (st == TS_T4);
   assign idle_o     = (st == TS_IDLE);

   assert_reset_idle_R1: assert property (@(posedge clk)
      rst |=> (tstate == 3'd0));
   assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
      cycle_done |=> !cycle_done);
   assert_special_idles_R9: assert property (@(posedge clk) disable iff (rst)
      (cycle_done && spec) |=> idle_o);
endmodule

// File: tb/bus_tstate_seq_test.sv
module bus_tstate_seq_test;
   localparam int GAP = 2;
   logic clk = 1'b0;
   logic rst, bus_req, rdy_async, rdy_sync, special_req;
   logic [2:0] idle_cause;
   logic [2:0] tstate;
   logic cycle_done, idle_o;
   int checks = 0, errors = 0;

   bus_tstate_seq uut (
      .clk(clk), .rst(rst), .bus_req(bus_req), .rdy_async(rdy_async),
      .rdy_sync(rdy_sync), .idle_cause(idle_cause), .special_req(special_req),
      .tstate(tstate), .cycle_done(cycle_done), .idle_o(idle_o));

   always #10 clk = ~clk;

   // reference model state
   int m_st = 0, m_gap = 0;
   bit m_spec = 0, m_s1 = 1, m_s2 = 1;

   function automatic string auto_tag(int st, bit r, bit [2:0] cs, int gap, bit spec);
      if (r) return "R1";
      case (st)
         0: return (gap != 0) ? "R9" : ((|cs) ? "R7" : "R2");
         1, 2: return "R2";
         3, 4: return "R3";
         default: return spec ? "R9" : ((|cs) ? "R7" : "R8");
      endcase
   endfunction

   function automatic int next_state(int st, bit req, bit hold, bit spec, bit rdy);
      case (st)
         0: return (req && !hold) ? 1 : 0;
         1: return 2;
         2: return 3;
         3, 4: return rdy ? 5 : 4;
         default: return (req && !hold && !spec) ? 1 : 0;
      endcase
   endfunction

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(bit r, bit req, bit ra, bit rs, bit [2:0] cs, bit sp, string tag);
      string t;
      int nst;
      bit hold;
      rst = r; bus_req = req; rdy_async = ra; rdy_sync = rs;
      idle_cause = cs; special_req = sp;
      @(posedge clk);
      #1;
      t = (tag == "") ? auto_tag(m_st, r, cs, m_gap, m_spec) : tag;
      hold = (|cs) || (m_gap != 0);
      if (r) begin
         nst = 0; m_gap = 0; m_spec = 0; m_s1 = 1; m_s2 = 1;
      end else begin
         nst = next_state(m_st, req, hold, m_spec, m_s2 | rs);
         if (m_st == 5 && m_spec) m_gap = GAP;
         else if (m_gap != 0) m_gap--;
         if (nst == 1) m_spec = sp;
         m_s2 = m_s1; m_s1 = ra;
      end
      m_st = nst;
      chk(t, int'(tstate), m_st);
      chk("R6", int'(cycle_done), (m_st == 5) ? 1 : 0);
      chk("R10", int'(idle_o), (m_st == 0) ? 1 : 0);
      #1;
   endtask

   initial begin
      #4_000_000;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      // R1: reset state
      for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 3'b000, 0, "R1");
      // R2 / R8: ready bus, back-to-back cycles
      for (int i = 0; i < 10; i++) step(0, 1, 1, 1, 3'b000, 0, "");
      // R3 / R4: both ready low, then async ready rises; exit after sync latency
      for (int i = 0; i < 6; i++) step(0, 1, 0, 0, 3'b000, 0, "R3");
      for (int i = 0; i < 8; i++) step(0, 1, 1, 0, 3'b000, 0, "R4");
      // R5: async low, sync ready high mid-cycle ends waits at once
      for (int i = 0; i < 5; i++) step(0, 1, 0, 0, 3'b000, 0, "R3");
      for (int i = 0; i < 4; i++) step(0, 1, 0, 1, 3'b000, 0, "R5");
      // R7: each idle cause blocks start
      for (int b = 0; b < 3; b++)
         for (int i = 0; i < 6; i++) step(0, 1, 1, 1, 3'(1 << b), 0, "");
      // R9: special cycle followed by gap
      for (int i = 0; i < 3; i++) step(0, 0, 1, 1, 3'b000, 0, "");
      for (int i = 0; i < 12; i++) step(0, 1, 1, 1, 3'b000, 1, "");
      // mid-run reset
      step(1, 1, 1, 1, 3'b000, 0, "R1");
      // constrained random
      for (int i = 0; i < 4000; i++) begin
         bit [2:0] cs;
         for (int b = 0; b < 3; b++) cs[b] = ($urandom_range(0, 15) == 0);
         step(($urandom_range(0, 499) == 0), ($urandom_range(0, 9) < 8),
              ($urandom_range(0, 9) < 3), ($urandom_range(0, 9) < 3), cs,
              ($urandom_range(0, 4) == 0), "");
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule